// File: doc/BRIEF.md
# Multi-Window Counter Range Comparator

This block watches a 32-bit counter value and tests it against a table of eight programmable windows. Each window holds an inclusive lower bound, an inclusive upper bound, an enable and an 8-bit event code. The test runs only when a scan strobe is high. The block drives one "inside" flag per window. It can be used only to ask whether the count lies in a window, without any event.

When an enabled window changes from outside to inside at a scan, the block records a pending event for that window. Pending events leave the block one per clock cycle, lowest window number first. Each one is a single-cycle valid pulse that carries the window's event code and its index. A window re-entering its range while its event still waits does not add a second event. Writing any field of a window drops that window's flag and pending event, so that an edge against old bounds is never reported.

The table is loaded through a simple write port. The port has a window index, a field select and a 32-bit data word.

Top module: `range_watch`

## Requirements
- R1: At a clock edge with `scan_i` high, `hit_o[i]` becomes 1 exactly when window i is enabled and lower ≤ `pv_i` ≤ upper (both bounds inclusive). Without a scan or a write to that window, `hit_o` holds its value.
- R2: Bounds are compared as unsigned 32-bit numbers, so the values 0 and 32'hFFFF_FFFF are valid bounds. A window whose lower bound is greater than its upper bound never matches.
- R3: Field 2 of a window is its control word: bit 8 is the enable and bits 7:0 are the event code. A disabled window keeps its flag at 0 and raises no event.
- R4: An event is raised only on an outside-to-inside change seen at a scan. It is not raised again while the window stays inside.
- R5: Pending events are issued one per clock, lowest window index first. The first one is visible in the cycle after the scan edge. Each later pending event follows in the next cycle.
- R6: An event is `evt_vld_o` high for one cycle, with the window's code on `evt_id_o` and its index on `evt_idx_o`. Both are 0 when `evt_vld_o` is low.
- R7: A window that leaves and re-enters its range while its event is still pending does not queue a second event.
- R8: A write to field 0 (lower bound), 1 (upper bound) or 2 (control) of window i clears `hit_o[i]` and the pending event of window i. This takes priority over a scan in the same cycle. Writes to field 3 have no effect.
- R9: After reset all windows are disabled, all flags are 0 and no event is pending or issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_i | input | 1 | Scan strobe: evaluate the windows this cycle |
| pv_i | input | 32 | Counter value under test |
| wr_en_i | input | 1 | Table write strobe |
| wr_win_i | input | 3 | Window index for the write |
| wr_fld_i | input | 2 | Field: 0 lower, 1 upper, 2 control, 3 unused |
| wr_data_i | input | 32 | Write data |
| hit_o | output | 8 | Per-window inside flags |
| evt_vld_o | output | 1 | Event valid pulse |
| evt_id_o | output | 8 | Event code of the issued window |
| evt_idx_o | output | 3 | Index of the issued window |

## Verification
A wrong stored inside state shows up at `hit_o` in the cycle after the scan that set it. It shows up again as a missing or extra event one cycle later. A corrupted pending mask shows up as events out of index order, as gaps in the one-per-cycle train, or as a duplicate for a window that re-entered while waiting. These errors are visible within a few cycles of a scan. The back-to-back scan cases and the write issued in the same cycle as a scan expose the priority between set, issue and clear at the first cycle where they disagree.

// File: rtl/range_watch.sv
`timescale 1ns/1ps
module range_watch #(
  parameter int NWIN = 8,
  parameter int PW   = 32,
  parameter int IDW  = 8,
  localparam int XW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_i,
  input  logic [PW-1:0]  pv_i,
  input  logic           wr_en_i,
  input  logic [XW-1:0]  wr_win_i,
  input  logic [1:0]     wr_fld_i,
  input  logic [31:0]    wr_data_i,
  output logic [NWIN-1:0] hit_o,
  output logic           evt_vld_o,
  output logic [IDW-1:0] evt_id_o,
  output logic [XW-1:0]  evt_idx_o
);

  logic [PW-1:0]   lo_q [NWIN];
  logic [PW-1:0]   hi_q [NWIN];
  logic [IDW-1:0]  id_q [NWIN];
  logic [NWIN-1:0] en_q, hit_q, pend_q;
  logic [NWIN-1:0] in_win, rise, wr_clr, pick_oh;
  logic [XW-1:0]   pick_idx;

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign in_win[i] = en_q[i] && (pv_i >= lo_q[i]) && (pv_i <= hi_q[i]);
  end

  wire wr_hit = wr_en_i && (wr_fld_i != 2'd3);
  assign wr_clr  = wr_hit ? (NWIN'(1) << wr_win_i) : '0;
  assign rise    = scan_i ? (in_win & ~hit_q) : '0;
  assign pick_oh = pend_q & (~pend_q + NWIN'(1));

  always_comb begin
    pick_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (pend_q[i]) pick_idx = XW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
        id_q[i] <= '0;
      end
      en_q <= '0;
    end else if (wr_en_i) begin
      case (wr_fld_i)
        2'd0: lo_q[wr_win_i] <= wr_data_i[PW-1:0];
        2'd1: hi_q[wr_win_i] <= wr_data_i[PW-1:0];
        2'd2: begin
          id_q[wr_win_i] <= wr_data_i[IDW-1:0];
          en_q[wr_win_i] <= wr_data_i[IDW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q     <= '0;
      pend_q    <= '0;
      evt_vld_o <= 1'b0;
      evt_id_o  <= '0;
      evt_idx_o <= '0;
    end else begin
      hit_q     <= (scan_i ? in_win : hit_q) & ~wr_clr;
      pend_q    <= (pend_q | rise) & ~pick_oh & ~wr_clr;
      evt_vld_o <= |pend_q;
      evt_idx_o <= (|pend_q) ? pick_idx : '0;
      evt_id_o  <= (|pend_q) ? id_q[pick_idx] : '0;
    end
  end

  assign hit_o = hit_q;

endmodule

module range_watch_chk #(
  parameter int NWIN = 8,
  parameter int IDW  = 8,
  localparam int XW  = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_i,
  input logic            wr_en_i,
  input logic [XW-1:0]   wr_win_i,
  input logic [1:0]      wr_fld_i,
  input logic [NWIN-1:0] hit_o,
  input logic [NWIN-1:0] en_q,
  input logic [NWIN-1:0] pend_q,
  input logic            evt_vld_o,
  input logic [IDW-1:0]  evt_id_o,
  input logic [XW-1:0]   evt_idx_o
);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_vld_o |-> (evt_id_o == '0 && evt_idx_o == '0));

  // R1
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_i && !wr_en_i) |=> $stable(hit_o));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~en_q) == '0);

  // R5
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld_o |-> ((($past(pend_q) >> evt_idx_o) & NWIN'(1)) == NWIN'(1)
                   && ($past(pend_q) & ((NWIN'(1) << evt_idx_o) - NWIN'(1))) == '0));

  // R7
  issued_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld_o |-> !pend_q[evt_idx_o]);

  // R8
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_fld_i != 2'd3) |=> (!hit_o[$past(wr_win_i)] && !pend_q[$past(wr_win_i)]));

endmodule

bind range_watch range_watch_chk #(.NWIN(NWIN), .IDW(IDW)) u_chk (.*);

// File: tb/sim_range_watch.sv
`timescale 1ns/1ps
module sim_range_watch;
  logic        clk = 0, rst_n = 0, scan_i = 0, wr_en_i = 0;
  logic [31:0] pv_i = 0, wr_data_i = 0;
  logic [2:0]  wr_win_i = 0;
  logic [1:0]  wr_fld_i = 0;
  logic [7:0]  hit_o, evt_id_o;
  logic        evt_vld_o;
  logic [2:0]  evt_idx_o;
  int checks = 0, errors = 0;
  bit done = 0;

  range_watch u0 (.*);

  always #10 clk = ~clk;

  // pv, expected flags, expected event mask
  localparam logic [47:0] VEC [0:13] = '{
    {32'd50,         8'h00, 8'h00},
    {32'd0,          8'h04, 8'h04},
    {32'd100,        8'h01, 8'h01},
    {32'd150,        8'h03, 8'h02},
    {32'd195,        8'h83, 8'h80},
    {32'd200,        8'h83, 8'h00},
    {32'd201,        8'h82, 8'h00},
    {32'd1000,       8'hC0, 8'h40},
    {32'hFFFF_FFFF,  8'h08, 8'h08},
    {32'd150,        8'h03, 8'h03},
    {32'd0,          8'h04, 8'h04},
    {32'd190,        8'h83, 8'h83},
    {32'd450,        8'h80, 8'h00},
    {32'hFFFF_FFF0,  8'h08, 8'h08}
  };

  function automatic logic [7:0] code_of(input int w);
    return (w == 7) ? 8'd255 : 8'(w * 17);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int w, input int f, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_win_i = 3'(w); wr_fld_i = 2'(f); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic expect_events(input logic [7:0] mask, input int span);
    int order [8];
    int n = 0;
    for (int i = 0; i < 8; i++) if (mask[i]) begin order[n] = i; n++; end
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      if (k < n) begin
        chk(evt_vld_o, "R5", "event valid", evt_vld_o, 1);
        chk(evt_idx_o == 3'(order[k]), "R5", "event index", evt_idx_o, order[k]);
        chk(evt_id_o == code_of(order[k]), "R6", "event code", evt_id_o, code_of(order[k]));
      end else begin
        chk(!evt_vld_o, "R4", "no extra event", evt_vld_o, 0);
        chk(evt_id_o == 0 && evt_idx_o == 0, "R6", "idle code/index", {evt_id_o, 5'b0, evt_idx_o}, 0);
      end
    end
  endtask

  task automatic scan(input logic [31:0] pv, input logic [7:0] exp_hit,
                      input logic [7:0] exp_ev, input string req);
    @(negedge clk);
    pv_i = pv; scan_i = 1;
    @(negedge clk);
    scan_i = 0;
    chk(hit_o == exp_hit, req, "inside flags", hit_o, exp_hit);
    expect_events(exp_ev, 5);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(hit_o == 0, "R9", "flags after reset", hit_o, 0);
    chk(!evt_vld_o, "R9", "no event after reset", evt_vld_o, 0);
    rst_n = 1;
    scan(32'd150, 8'h00, 8'h00, "R9");

    wr(0, 0, 100);          wr(0, 1, 200);          wr(0, 2, {23'd0, 1'b1, code_of(0)});
    wr(1, 0, 150);          wr(1, 1, 300);          wr(1, 2, {23'd0, 1'b1, code_of(1)});
    wr(2, 0, 0);            wr(2, 1, 0);            wr(2, 2, {23'd0, 1'b1, code_of(2)});
    wr(3, 0, 32'hFFFF_FFF0); wr(3, 1, 32'hFFFF_FFFF); wr(3, 2, {23'd0, 1'b1, code_of(3)});
    wr(4, 0, 500);          wr(4, 1, 400);          wr(4, 2, {23'd0, 1'b1, code_of(4)});
    wr(5, 0, 100);          wr(5, 1, 200);          wr(5, 2, {23'd0, 1'b0, code_of(5)});
    wr(6, 0, 1000);         wr(6, 1, 1000);         wr(6, 2, {23'd0, 1'b1, code_of(6)});
    wr(7, 0, 190);          wr(7, 1, 1000);         wr(7, 2, {23'd0, 1'b1, code_of(7)});

    // R1 R2 R3 R4 R5: vector walk (w4 inverted, w5 disabled)
    for (int v = 0; v < 14; v++)
      scan(VEC[v][47:16], VEC[v][15:8], VEC[v][7:0], "R1/R2");

    // R1: value changes without scan leave flags alone
    @(negedge clk); pv_i = 150;
    repeat (3) @(negedge clk);
    chk(hit_o == 8'h08, "R1", "flags hold without scan", hit_o, 8'h08);
    chk(!evt_vld_o, "R4", "no event without scan", evt_vld_o, 0);

    // R7: back-to-back scans 190, 50, 190
    @(negedge clk); pv_i = 190; scan_i = 1;
    @(negedge clk); pv_i = 50;
    chk(!evt_vld_o, "R5", "nothing in scan cycle", evt_vld_o, 0);
    @(negedge clk); pv_i = 190;
    chk(evt_vld_o && evt_idx_o == 0, "R7", "first event w0", evt_idx_o, 0);
    @(negedge clk); scan_i = 0;
    chk(evt_vld_o && evt_idx_o == 1, "R7", "second event w1", evt_idx_o, 1);
    @(negedge clk);
    chk(evt_vld_o && evt_idx_o == 0, "R7", "re-entry event w0", evt_idx_o, 0);
    @(negedge clk);
    chk(evt_vld_o && evt_idx_o == 7 && evt_id_o == 8'd255, "R7", "pending w7 once", evt_idx_o, 7);
    @(negedge clk);
    chk(!evt_vld_o, "R7", "no duplicate w1/w7", {evt_vld_o, evt_idx_o}, 0);
    chk(hit_o == 8'h83, "R1", "flags after re-entry", hit_o, 8'h83);

    // R8: write to w1 in the same cycle as a scan
    scan(32'd50, 8'h00, 8'h00, "R8");
    @(negedge clk);
    pv_i = 150; scan_i = 1;
    wr_en_i = 1; wr_win_i = 1; wr_fld_i = 1; wr_data_i = 300;
    @(negedge clk);
    scan_i = 0; wr_en_i = 0;
    chk(hit_o == 8'h01, "R8", "written window flag cleared", hit_o, 8'h01);
    expect_events(8'h01, 4);
    scan(32'd150, 8'h03, 8'h02, "R8");

    // R3: enable w5
    wr(5, 2, {23'd0, 1'b1, code_of(5)});
    scan(32'd150, 8'h23, 8'h20, "R3");

    // R8: field 3 write has no effect
    wr(0, 3, 32'hFFFF_FFFF);
    scan(32'd150, 8'h23, 8'h00, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule